// File: doc/BRIEF.md
# Flash Access Protection Guard

This block sits between the CPU and debug masters and an on-chip program flash. It decides, per request, whether a read or a write may reach the array. The decision uses three inputs. The first is a protection level taken from option bytes. The second is a write-protect mask with one bit per 4 KB sector. The third is the live state of the debugger connection. The guard also works out the boot source from a boot pin and a boot-selector option bit, and it drives an enable that powers the debug port.

The level, the sector mask and the boot source are captured once, on the first clock edge after reset is released. They are then held until the next reset. When a request is permitted, it is forwarded to the array as a read or write enable in the same cycle. When a request is refused, no enable reaches the array, the read data seen by the master in the following cycle is forced to zero, and a single-cycle error pulse is raised.

Top module: `flash_guard`

## Requirements
- R1: The 2-bit level code decodes as 0 = open, 1 = guarded, 2 = locked. Code 3 behaves exactly like code 1 (guarded).
- R2: In the open level, reads are always forwarded, and writes are forwarded unless the target sector is write-protected (R5). The debugger state and the boot source have no effect.
- R3: In the guarded level, every read and every write is refused while `dbg_attached_i` is high. Every read and every write is also refused when the resolved boot source is SRAM.
- R4: In the locked level, `dbg_en_o` is low and a boot selection of SRAM resolves to user flash instead. Accesses are forwarded whatever the state of `dbg_attached_i`, subject to R5.
- R5: Write-protect bit i covers byte addresses i*4096 to i*4096+4095. A write to a sector whose bit is 1 is refused. Reads are not affected by the mask.
- R6: The boot source code `boot_src_o` is resolved as follows: boot pin 0 gives user flash (0); boot pin 1 with selector 1 gives system memory (1); boot pin 1 with selector 0 gives SRAM (2).
- R7: When a request is refused, its enable (`flash_rd_en_o` or `flash_wr_en_o`) stays low in the request cycle. `err_o` is high in the next cycle. For a refused read, `rdata_o` is zero in that next cycle.
- R8: When a read is granted, `rdata_o` equals `flash_rdata_i` in the following cycle. A cycle in which every request is granted is followed by `err_o` low.
- R9: The level, mask and boot inputs are sampled on the first clock edge after reset release. Later changes to them have no effect until the next reset.
- R10: During reset, `dbg_en_o`, `err_o`, `rdata_o`, both enables and `boot_src_o` (user flash) are all zero. Requests presented before the capture edge are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_level_i | input | 2 | Protection level code from option bytes |
| opt_wrp_i | input | NUM_SECT (8) | Write-protect mask, 1 = sector protected |
| opt_boot_sel_i | input | 1 | Boot selector option bit |
| boot_pin_i | input | 1 | Boot pin |
| dbg_attached_i | input | 1 | Debugger connected |
| rd_req_i | input | 1 | Read request strobe |
| wr_req_i | input | 1 | Write request strobe |
| req_addr_i | input | ADDR_W (15) | Byte address of the request |
| flash_rdata_i | input | DATA_W (32) | Read data from the array, one cycle after its enable |
| flash_addr_o | output | ADDR_W (15) | Address forwarded to the array |
| flash_rd_en_o | output | 1 | Granted read enable to the array |
| flash_wr_en_o | output | 1 | Granted write enable to the array |
| rdata_o | output | DATA_W (32) | Read data returned to the master, zero when refused |
| err_o | output | 1 | One-cycle pulse after a refused request |
| dbg_en_o | output | 1 | Debug port enable |
| boot_src_o | output | 2 | Resolved boot source code |

## Verification
The two array enables are combinational. They are due in the same cycle as the request, so they are compared a half period after the inputs change. `err_o` and `rdata_o` come from a single register stage, so the expected values for them are computed at the request edge and compared at the following falling edge. `boot_src_o` and `dbg_en_o` change only at the capture edge. A behavioural model in the bench updates on the same edges and is compared with every output in every cycle. This way a result that arrives one cycle early or one cycle late shows up as a mismatch.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

   typedef enum logic [1:0] {
      LVL_OPEN  = 2'd0,
      LVL_GUARD = 2'd1,
      LVL_LOCK  = 2'd2
   } lvl_e;

   typedef enum logic [1:0] {
      BOOT_FLASH  = 2'd0,
      BOOT_SYSMEM = 2'd1,
      BOOT_SRAM   = 2'd2
   } boot_e;

   typedef struct packed {
      logic  valid;
      lvl_e  lvl;
      boot_e boot;
   } cfg_t;

   // Unused code 3 folds onto the guarded level (R1)
   function automatic lvl_e decode_lvl(input logic [1:0] code);
      case (code)
         2'd0:    return LVL_OPEN;
         2'd2:    return LVL_LOCK;
         default: return LVL_GUARD;
      endcase
   endfunction

   // Boot source from pin and selector; SRAM is barred when locked (R4, R6)
   function automatic boot_e resolve_boot(input logic pin, input logic sel, input lvl_e lvl);
      if (!pin)             return BOOT_FLASH;
      if (sel)              return BOOT_SYSMEM;
      if (lvl == LVL_LOCK)  return BOOT_FLASH;
      return BOOT_SRAM;
   endfunction

endpackage

// File: rtl/fpg_cfg_latch.sv
module fpg_cfg_latch
   import fpg_pkg::*;
#(
   parameter int NUM_SECT = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          lvl_code_i,
   input  logic [NUM_SECT-1:0] wrp_i,
   input  logic                boot_pin_i,
   input  logic                boot_sel_i,
   output cfg_t                cfg_o,
   output logic [NUM_SECT-1:0] wrp_o
);

   cfg_t                cfg_q;
   logic [NUM_SECT-1:0] wrp_q;
   lvl_e                lvl_new;

   assign lvl_new = decode_lvl(lvl_code_i);

   // One-shot capture on the first edge after reset release (R9)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.valid <= 1'b0;
         cfg_q.lvl   <= LVL_LOCK;
         cfg_q.boot  <= BOOT_FLASH;
         wrp_q       <= '1;
      end else if (!cfg_q.valid) begin
         cfg_q.valid <= 1'b1;
         cfg_q.lvl   <= lvl_new;
         cfg_q.boot  <= resolve_boot(boot_pin_i, boot_sel_i, lvl_new);
         wrp_q       <= wrp_i;
      end
   end

   assign cfg_o = cfg_q;
   assign wrp_o = wrp_q;

endmodule

// File: rtl/fpg_sector_decode.sv
module fpg_sector_decode #(
   parameter int NUM_SECT = 8,
   parameter int SECT_W   = 3
) (
   input  logic [SECT_W-1:0]   sect_i,
   input  logic [NUM_SECT-1:0] wrp_i,
   output logic                prot_o
);

   logic [NUM_SECT-1:0] hit;

   for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
      assign hit[g] = (sect_i == SECT_W'(g));
   end

   assign prot_o = |(hit & wrp_i);

endmodule

// File: rtl/fpg_access_rule.sv
module fpg_access_rule
   import fpg_pkg::*;
(
   input  cfg_t cfg_i,
   input  logic dbg_attached_i,
   input  logic rd_req_i,
   input  logic wr_req_i,
   input  logic wr_prot_i,
   output logic rd_ok_o,
   output logic wr_ok_o,
   output logic deny_o
);

   logic guard_block;
   logic path_open;

   // Guarded level: debugger or SRAM boot closes the array (R3)
   assign guard_block = (cfg_i.lvl == LVL_GUARD) &&
                        (dbg_attached_i || (cfg_i.boot == BOOT_SRAM));
   assign path_open   = cfg_i.valid && !guard_block;

   assign rd_ok_o = rd_req_i && path_open;
   assign wr_ok_o = wr_req_i && path_open && !wr_prot_i;
   assign deny_o  = (rd_req_i && !rd_ok_o) || (wr_req_i && !wr_ok_o);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import fpg_pkg::*;
#(
   parameter int FLASH_KB  = 32,
   parameter int SECTOR_KB = 4,
   parameter int DATA_W    = 32,
   localparam int NUM_SECT = FLASH_KB / SECTOR_KB,
   localparam int ADDR_W   = $clog2(FLASH_KB * 1024),
   localparam int SECT_SH  = $clog2(SECTOR_KB * 1024),
   localparam int SECT_W   = ADDR_W - SECT_SH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          opt_level_i,
   input  logic [NUM_SECT-1:0] opt_wrp_i,
   input  logic                opt_boot_sel_i,
   input  logic                boot_pin_i,
   input  logic                dbg_attached_i,
   input  logic                rd_req_i,
   input  logic                wr_req_i,
   input  logic [ADDR_W-1:0]   req_addr_i,
   input  logic [DATA_W-1:0]   flash_rdata_i,
   output logic [ADDR_W-1:0]   flash_addr_o,
   output logic                flash_rd_en_o,
   output logic                flash_wr_en_o,
   output logic [DATA_W-1:0]   rdata_o,
   output logic                err_o,
   output logic                dbg_en_o,
   output logic [1:0]          boot_src_o
);

   if (FLASH_KB < 16 || FLASH_KB > 32) begin : g_bad_size
      $error("flash_guard: FLASH_KB must lie in 16..32");
   end
   if ((FLASH_KB % SECTOR_KB) != 0 || (1 << SECT_W) != NUM_SECT) begin : g_bad_sect
      $error("flash_guard: sector count must be a power of two dividing the flash");
   end

   cfg_t                cfg;
   logic                cfg_valid;
   logic [NUM_SECT-1:0] wrp;
   logic                wr_prot;
   logic                rd_ok, wr_ok, deny;
   logic                rd_ok_q, err_q;

   fpg_cfg_latch #(.NUM_SECT(NUM_SECT)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_code_i (opt_level_i),
      .wrp_i      (opt_wrp_i),
      .boot_pin_i (boot_pin_i),
      .boot_sel_i (opt_boot_sel_i),
      .cfg_o      (cfg),
      .wrp_o      (wrp)
   );

   fpg_sector_decode #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_sect (
      .sect_i (req_addr_i[ADDR_W-1:SECT_SH]),
      .wrp_i  (wrp),
      .prot_o (wr_prot)
   );

   fpg_access_rule u_rule (
      .cfg_i          (cfg),
      .dbg_attached_i (dbg_attached_i),
      .rd_req_i       (rd_req_i),
      .wr_req_i       (wr_req_i),
      .wr_prot_i      (wr_prot),
      .rd_ok_o        (rd_ok),
      .wr_ok_o        (wr_ok),
      .deny_o         (deny)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ok_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         rd_ok_q <= rd_ok;
         err_q   <= deny;
      end
   end

   assign cfg_valid     = cfg.valid;
   assign flash_addr_o  = req_addr_i;
   assign flash_rd_en_o = rd_ok;
   assign flash_wr_en_o = wr_ok;
   assign rdata_o       = rd_ok_q ? flash_rdata_i : '0;
   assign err_o         = err_q;
   assign dbg_en_o      = cfg.valid && (cfg.lvl != LVL_LOCK);
   assign boot_src_o    = cfg.boot;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_i,
   input logic              wr_req_i,
   input logic              flash_rd_en_o,
   input logic              flash_wr_en_o,
   input logic [DATA_W-1:0] flash_rdata_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              err_o,
   input logic              dbg_en_o,
   input logic [1:0]        boot_src_o,
   input logic              cfg_valid_i
);

   p_deny_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_req_i && !flash_rd_en_o) || (wr_req_i && !flash_wr_en_o)) |=> err_o);

   p_deny_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && !flash_rd_en_o) |=> (rdata_o == '0));

   p_rd_en_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flash_rd_en_o |-> rd_req_i);

   p_wr_en_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flash_wr_en_o |-> wr_req_i);

   p_rd_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && flash_rd_en_o) |=> (rdata_o == flash_rdata_i));

   p_ok_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((!rd_req_i || flash_rd_en_o) && (!wr_req_i || flash_wr_en_o)) |=> !err_o);

   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid_i |=> (cfg_valid_i && $stable(boot_src_o) && $stable(dbg_en_o)));

   p_lock_no_sram_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid_i && !dbg_en_o) |-> (boot_src_o != 2'd2));

endmodule

bind flash_guard flash_guard_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rd_req_i      (rd_req_i),
   .wr_req_i      (wr_req_i),
   .flash_rd_en_o (flash_rd_en_o),
   .flash_wr_en_o (flash_wr_en_o),
   .flash_rdata_i (flash_rdata_i),
   .rdata_o       (rdata_o),
   .err_o         (err_o),
   .dbg_en_o      (dbg_en_o),
   .boot_src_o    (boot_src_o),
   .cfg_valid_i   (cfg_valid)
);

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;

   localparam int NS = 8;
   localparam int AW = 15;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    opt_level = 2'd0;
   logic [NS-1:0] opt_wrp = '0;
   logic          opt_sel = 1'b0;
   logic          boot_pin = 1'b0;
   logic          dbg = 1'b0;
   logic          rd_req = 1'b0;
   logic          wr_req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] frd = '0;
   logic [AW-1:0] f_addr;
   logic          f_rd_en, f_wr_en, err, dbg_en;
   logic [DW-1:0] rdata;
   logic [1:0]    boot_src;

   int checks = 0;
   int fails  = 0;
   string tag = "R10";
   int seed = 7;

   always #5 clk = ~clk;

   flash_guard dut_i (
      .clk(clk), .rst_n(rst_n), .opt_level_i(opt_level), .opt_wrp_i(opt_wrp),
      .opt_boot_sel_i(opt_sel), .boot_pin_i(boot_pin), .dbg_attached_i(dbg),
      .rd_req_i(rd_req), .wr_req_i(wr_req), .req_addr_i(addr), .flash_rdata_i(frd),
      .flash_addr_o(f_addr), .flash_rd_en_o(f_rd_en), .flash_wr_en_o(f_wr_en),
      .rdata_o(rdata), .err_o(err), .dbg_en_o(dbg_en), .boot_src_o(boot_src)
   );

   // Array model: data appears one cycle after the address
   function automatic logic [DW-1:0] pat(input int a);
      return 32'hC0DE_0000 ^ (a * 32'h0001_0003);
   endfunction
   always @(posedge clk) frd <= pat(int'(addr));

   // ---------------- reference model ----------------
   int m_valid = 0, m_lvl = 2, m_boot = 0, m_wrp = 255;
   int m_err = 0, m_rd_ok = 0, m_last = 0;

   function automatic int lvl_of(input int code);
      return (code == 3) ? 1 : code;
   endfunction
   function automatic int boot_of(input int pin, input int sel, input int lvl);
      if (pin == 0) return 0;
      if (sel == 1) return 1;
      if (lvl == 2) return 0;
      return 2;
   endfunction
   function automatic bit open_now();
      if (m_valid == 0) return 0;
      if (m_lvl == 1 && (dbg || m_boot == 2)) return 0;
      return 1;
   endfunction
   function automatic bit exp_rd();
      return rd_req && open_now();
   endfunction
   function automatic bit sect_prot();
      return ((m_wrp >> (int'(addr) / 4096)) & 1) == 1;
   endfunction
   function automatic bit exp_wr();
      return wr_req && open_now() && !sect_prot();
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid = 0; m_err = 0; m_rd_ok = 0;
      end else begin
         m_err   = ((rd_req && !exp_rd()) || (wr_req && !exp_wr())) ? 1 : 0;
         m_rd_ok = exp_rd() ? 1 : 0;
         m_last  = int'(addr);
         if (m_valid == 0) begin
            m_lvl   = lvl_of(int'(opt_level));
            m_boot  = boot_of(int'(boot_pin), int'(opt_sel), m_lvl);
            m_wrp   = int'(opt_wrp);
            m_valid = 1;
         end
      end
   end

   task automatic chk(input bit ok, input string t, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
      end
   endtask

   // Compare every output on every falling edge
   always @(negedge clk) begin
      automatic string et;
      automatic logic [DW-1:0] er;
      if (!rst_n) begin
         chk(f_rd_en == 0 && f_wr_en == 0, "R10", "enables in reset", {f_rd_en, f_wr_en}, 0);
         chk(err == 0 && rdata == 0, "R10", "err/rdata in reset", {err, rdata}, 0);
         chk(dbg_en == 0 && boot_src == 0, "R10", "dbg/boot in reset", {dbg_en, boot_src}, 0);
      end else begin
         et = (wr_req && m_valid && sect_prot()) ? "R5" : tag;
         chk(f_rd_en == exp_rd(), et, "rd_en", f_rd_en, exp_rd());
         chk(f_wr_en == exp_wr(), et, "wr_en", f_wr_en, exp_wr());
         chk(f_addr == addr, et, "addr fwd", f_addr, addr);
         chk(err == m_err[0], "R7", "err", err, m_err);
         er = (m_rd_ok == 1) ? pat(m_last) : '0;
         chk(rdata == er, (m_rd_ok == 1) ? "R8" : "R7", "rdata", rdata, er);
         chk(dbg_en == (m_valid == 1 && m_lvl != 2), (m_lvl == 2) ? "R4" : tag, "dbg_en",
             dbg_en, (m_valid == 1 && m_lvl != 2));
         chk(boot_src == ((m_valid == 1) ? 2'(m_boot) : 2'd0), "R6", "boot_src",
             boot_src, m_boot);
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic start(input int lvl, input int pin, input int sel, input int wrp,
                        input string t);
      step();
      rst_n = 1'b0; rd_req = 0; wr_req = 0; tag = "R10";
      opt_level = 2'(lvl); boot_pin = pin[0]; opt_sel = sel[0]; opt_wrp = NS'(wrp);
      step(); step();
      rst_n = 1'b1;
      rd_req = 1'b1;  // request before the capture edge is refused (R10)
      step();
      rd_req = 1'b0;
      tag = t;
   endtask

   task automatic traffic(input int n, input int dbg_mode);
      for (int i = 0; i < n; i++) begin
         seed = seed * 1103515245 + 12345;
         rd_req = seed[16];
         wr_req = seed[17];
         addr   = AW'(seed >>> 3);
         dbg    = (dbg_mode == 2) ? seed[20] : dbg_mode[0];
         step();
      end
      rd_req = 0; wr_req = 0; dbg = 0;
      step();
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      step(); step();
      // R2 / R5: open level, sectors 0 and 2 protected, debugger toggling
      start(0, 0, 0, 8'b0000_0101, "R2");
      traffic(60, 2);
      // R3: guarded level booting from flash, debugger toggling
      start(1, 0, 0, 8'h00, "R3");
      traffic(60, 2);
      // R3: guarded level with SRAM boot, everything refused
      start(1, 1, 0, 8'h00, "R3");
      traffic(40, 0);
      // R4: locked level, SRAM request falls back to flash, debugger ignored
      start(2, 1, 0, 8'b1000_0000, "R4");
      traffic(60, 2);
      // R1: code 3 acts as guarded
      start(3, 0, 0, 8'h00, "R1");
      traffic(40, 2);
      // R6: boot decode variants at the open level
      start(0, 1, 1, 8'h00, "R6");
      traffic(20, 1);
      start(0, 1, 0, 8'h00, "R6");
      traffic(20, 1);
      // R9: options change after capture and must be ignored
      start(0, 0, 0, 8'h00, "R9");
      opt_level = 2'd2; boot_pin = 1; opt_sel = 0; opt_wrp = '1;
      traffic(40, 2);
      step();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule